// File: doc/BRIEF.md
# Bus Activity Monitor with Watermarks

This block watches a single bus channel and turns a stream of one-cycle event pulses into a measure of load. A global tick generator divides an external millisecond strobe into sampling periods. During each period the channel adds a programmable weight to a saturating accumulator for every event. At the end of the period the accumulated total becomes the sample and the accumulator restarts from zero.

Each sample is judged in two ways. First, it is compared against an upper and a lower watermark. A streak counter on each side raises a status flag once a programmed number of consecutive periods breach that watermark. Second, the sample feeds a windowed exponential moving average, and the updated average is compared against an average band. A single level interrupt reports any set status flag whose source is enabled. Software programs the block through a flat word-addressed register port, reads back the average, and clears flags by writing ones.

Top module: `bus_activity_monitor`

## Requirements
- R1: After reset every register reads zero, the average readback reads zero and `irq` is low.
- R2: The period register (offset 0x00, low PERIOD_W bits) holds P. A period ends on every (P+1)-th `ms_strobe` pulse. The strobe count restarts after the ending strobe.
- R3: When the channel enable (control bit 31) is set, each cycle with `bus_event` high adds the weight register (offset 0x1C) to the accumulator. The sum saturates at 2^DATA_W-1. An event in the cycle that ends a period belongs to that period's sample. A period end is acted on only when periodic sampling (control bit 18) is set; otherwise accumulation continues across period ends.
- R4: At each acted-on period end, the average becomes avg + (sample-avg)>>(K+1) when the sample is not below the average, and avg - (avg-sample)>>(K+1) otherwise. K is control bits 13:10. The average reads at offset 0x20.
- R5: While the channel is disabled, the average readback equals the initial-average register (offset 0x10). The first period after enabling starts from that value.
- R6: With control bit 30 set, a sample above the upper watermark (offset 0x08) counts as an upper breach. When control bits 28:26 hold N, status bit 31 sets on the (N+1)-th consecutive upper breach, and the streak then restarts from zero.
- R7: With control bit 29 set, a sample below the lower watermark (offset 0x0C) counts as a lower breach. When control bits 25:23 hold N, status bit 30 sets on the (N+1)-th consecutive lower breach, and the streak then restarts from zero.
- R8: A period end whose sample does not breach a watermark clears that side's streak. Clearing that side's enable bit also clears its streak.
- R9: With control bit 21 set, status bit 29 sets when the updated average exceeds the average upper bound (offset 0x14). With control bit 20 set, status bit 28 sets when the updated average falls below the average lower bound (offset 0x18).
- R10: Writing the status register (offset 0x24) clears each of bits 31:28 written as one, so writing all ones clears all of them. If a flag is raised in the same cycle as its clear, the flag stays set.
- R11: `irq` is high exactly when a set status bit has its enable set. The pairs are bit 31 with control bit 30, bit 30 with control bit 29, bit 29 with control bit 21, and bit 28 with control bit 20.
- R12: Writing zero to the control register stops the channel. The accumulator and both streaks clear, and no further flags are raised. Flags already set stay set.
- R13: All registers at offsets 0x00 to 0x1C read back what was last written, truncated to their widths. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_strobe | input | 1 | One-cycle pulse each millisecond |
| bus_event | input | 1 | One-cycle pulse per counted bus event |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte address of the register, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The status register can be written by software in the very cycle in which a period end raises a flag. The set must win over the clear.

To provoke this collision, the bench writes all ones to the status register on every cycle of a long window while heavy and then light traffic forces breaches, so that many period ends fall on clearing cycles. A reference model that applies clear before set is compared with the status readback and with `irq` on every clock.

Control writes that land on a period end are covered the same way: enables, K and the stop word are rewritten while ticks continue.

// File: rtl/mon_pkg.sv
package mon_pkg;

  localparam int ADDR_W = 6;
  localparam int NUM_W  = 3;
  localparam int K_W    = 4;

  // register offsets
  localparam logic [ADDR_W-1:0] A_PERIOD = 6'h00;
  localparam logic [ADDR_W-1:0] A_CTRL   = 6'h04;
  localparam logic [ADDR_W-1:0] A_UWM    = 6'h08;
  localparam logic [ADDR_W-1:0] A_LWM    = 6'h0C;
  localparam logic [ADDR_W-1:0] A_INIT   = 6'h10;
  localparam logic [ADDR_W-1:0] A_AVG_HI = 6'h14;
  localparam logic [ADDR_W-1:0] A_AVG_LO = 6'h18;
  localparam logic [ADDR_W-1:0] A_WEIGHT = 6'h1C;
  localparam logic [ADDR_W-1:0] A_AVG    = 6'h20;
  localparam logic [ADDR_W-1:0] A_STATUS = 6'h24;

  // control bit positions
  localparam int C_RUN      = 31;
  localparam int C_UP_EN    = 30;
  localparam int C_LO_EN    = 29;
  localparam int C_UP_NUM   = 26;
  localparam int C_LO_NUM   = 23;
  localparam int C_AHI_EN   = 21;
  localparam int C_ALO_EN   = 20;
  localparam int C_PERIODIC = 18;
  localparam int C_K        = 10;

  // saturating add against an inclusive limit
  function automatic logic [31:0] sat_add(input logic [31:0] a,
                                          input logic [31:0] b,
                                          input logic [31:0] lim);
    logic [32:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s > {1'b0, lim}) ? lim : s[31:0];
  endfunction

  // one step of the windowed exponential average
  function automatic logic [31:0] avg_step(input logic [31:0] cur,
                                           input logic [31:0] smp,
                                           input logic [K_W-1:0] k);
    logic [4:0] sh;
    sh = {1'b0, k} + 5'd1;
    if (smp >= cur) return cur + ((smp - cur) >> sh);
    else            return cur - ((cur - smp) >> sh);
  endfunction

endpackage

// File: rtl/mon_tick_gen.sv
module mon_tick_gen #(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ms_strobe,
  input  logic [PERIOD_W-1:0] period_m1,
  output logic                period_tick
);

  logic [PERIOD_W-1:0] ms_cnt_q;

  assign period_tick = ms_strobe && (ms_cnt_q >= period_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ms_cnt_q <= '0;
    else if (period_tick) ms_cnt_q <= '0;
    else if (ms_strobe)   ms_cnt_q <= ms_cnt_q + 1'b1;
  end

  // R2
  ms_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_strobe |=> $stable(ms_cnt_q))
    else $error("ms counter moved without strobe");

endmodule

// File: rtl/mon_accum.sv
module mon_accum
  import mon_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int WEIGHT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                chan_en,
  input  logic                sample_en,
  input  logic                bus_event,
  input  logic [WEIGHT_W-1:0] weight,
  output logic [DATA_W-1:0]   sample_sum
);

  localparam logic [31:0] LIM = 32'hFFFF_FFFF >> (32 - DATA_W);

  logic [DATA_W-1:0] acc_q;

  assign sample_sum = DATA_W'(sat_add(32'(acc_q),
                                      bus_event ? 32'(weight) : 32'd0, LIM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acc_q <= '0;
    else if (!chan_en)  acc_q <= '0;
    else if (sample_en) acc_q <= '0;
    else                acc_q <= sample_sum;
  end

  // R3
  acc_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && !sample_en) |=> (acc_q >= $past(acc_q)))
    else $error("accumulator decreased inside a period");

  // R12
  acc_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (acc_q == '0))
    else $error("accumulator kept value while stopped");

endmodule

// File: rtl/mon_breach_ctr.sv
module mon_breach_ctr
  import mon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             sample_en,
  input  logic             breach,
  input  logic [NUM_W-1:0] need_m1,
  output logic             fire
);

  logic [NUM_W-1:0] run_q;

  assign fire = active && sample_en && breach && (run_q >= need_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_q <= '0;
    else if (!active)           run_q <= '0;
    else if (sample_en) begin
      if (!breach || fire)      run_q <= '0;
      else                      run_q <= run_q + 1'b1;
    end
  end

  // R8
  streak_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !breach) |=> (run_q == '0))
    else $error("streak survived a clean period");

  // R6
  streak_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sample_en) |=> $stable(run_q))
    else $error("streak moved between period ends");

endmodule

// File: rtl/mon_average.sv
module mon_average
  import mon_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              sample_en,
  input  logic [DATA_W-1:0] sample,
  input  logic [K_W-1:0]    k_log,
  input  logic [DATA_W-1:0] init_avg,
  output logic [DATA_W-1:0] avg_q,
  output logic [DATA_W-1:0] avg_next
);

  assign avg_next = DATA_W'(avg_step(32'(avg_q), 32'(sample), k_log));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         avg_q <= '0;
    else if (!chan_en)  avg_q <= init_avg;
    else if (sample_en) avg_q <= avg_next;
  end

  // R4
  avg_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && sample_en) |=>
      ((avg_q >= $past(avg_q) && avg_q <= $past(sample)) ||
       (avg_q <= $past(avg_q) && avg_q >= $past(sample))))
    else $error("average left the span between old value and sample");

endmodule

// File: rtl/bus_activity_monitor.sv
module bus_activity_monitor
  import mon_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int WEIGHT_W = 16,
  parameter int PERIOD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_strobe,
  input  logic              bus_event,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);

  localparam int NSIDE = 2;

  logic [PERIOD_W-1:0] period_q;
  logic [31:0]         ctrl_q;
  logic [DATA_W-1:0]   uwm_q, lwm_q, init_q, ahi_q, alo_q;
  logic [WEIGHT_W-1:0] weight_q;
  logic [3:0]          status_q;

  logic                period_tick, chan_en, sample_en;
  logic [DATA_W-1:0]   sample_sum, avg_q, avg_next;
  logic [NSIDE-1:0]    streak_active, streak_breach, streak_fire;
  logic [NSIDE*NUM_W-1:0] streak_need;
  logic                avg_hi_evt, avg_lo_evt;
  logic [3:0]          flag_set, flag_clr, irq_mask;
  logic                status_wr;

  assign chan_en   = ctrl_q[C_RUN];
  assign sample_en = chan_en && ctrl_q[C_PERIODIC] && period_tick;
  assign status_wr = reg_wr && (reg_addr == A_STATUS);

  // register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      ctrl_q   <= '0;
      uwm_q    <= '0;
      lwm_q    <= '0;
      init_q   <= '0;
      ahi_q    <= '0;
      alo_q    <= '0;
      weight_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_PERIOD: period_q <= reg_wdata[PERIOD_W-1:0];
        A_CTRL:   ctrl_q   <= reg_wdata;
        A_UWM:    uwm_q    <= reg_wdata[DATA_W-1:0];
        A_LWM:    lwm_q    <= reg_wdata[DATA_W-1:0];
        A_INIT:   init_q   <= reg_wdata[DATA_W-1:0];
        A_AVG_HI: ahi_q    <= reg_wdata[DATA_W-1:0];
        A_AVG_LO: alo_q    <= reg_wdata[DATA_W-1:0];
        A_WEIGHT: weight_q <= reg_wdata[WEIGHT_W-1:0];
        default: ;
      endcase
    end
  end

  mon_tick_gen #(.PERIOD_W(PERIOD_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .ms_strobe(ms_strobe),
    .period_m1(period_q), .period_tick(period_tick)
  );

  mon_accum #(.DATA_W(DATA_W), .WEIGHT_W(WEIGHT_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .sample_en(sample_en),
    .bus_event(bus_event), .weight(weight_q), .sample_sum(sample_sum)
  );

  mon_average #(.DATA_W(DATA_W)) u_avg (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .sample_en(sample_en),
    .sample(sample_sum), .k_log(ctrl_q[C_K +: K_W]), .init_avg(init_q),
    .avg_q(avg_q), .avg_next(avg_next)
  );

  // side 0 watches the upper watermark, side 1 the lower one
  assign streak_active[0] = chan_en && ctrl_q[C_UP_EN];
  assign streak_active[1] = chan_en && ctrl_q[C_LO_EN];
  assign streak_breach[0] = sample_sum > uwm_q;
  assign streak_breach[1] = sample_sum < lwm_q;
  assign streak_need[0*NUM_W +: NUM_W] = ctrl_q[C_UP_NUM +: NUM_W];
  assign streak_need[1*NUM_W +: NUM_W] = ctrl_q[C_LO_NUM +: NUM_W];

  generate
    for (genvar g = 0; g < NSIDE; g++) begin : g_streak
      mon_breach_ctr u_ctr (
        .clk(clk), .rst_n(rst_n), .active(streak_active[g]),
        .sample_en(sample_en), .breach(streak_breach[g]),
        .need_m1(streak_need[g*NUM_W +: NUM_W]), .fire(streak_fire[g])
      );
    end
  endgenerate

  assign avg_hi_evt = sample_en && ctrl_q[C_AHI_EN] && (avg_next > ahi_q);
  assign avg_lo_evt = sample_en && ctrl_q[C_ALO_EN] && (avg_next < alo_q);

  // status[3..0] appear at register bits 31..28
  assign flag_set = {streak_fire[0], streak_fire[1], avg_hi_evt, avg_lo_evt};
  assign flag_clr = status_wr ? reg_wdata[31:28] : 4'b0000;
  assign irq_mask = {ctrl_q[C_UP_EN], ctrl_q[C_LO_EN],
                     ctrl_q[C_AHI_EN], ctrl_q[C_ALO_EN]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~flag_clr) | flag_set;
  end

  assign irq = |(status_q & irq_mask);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_PERIOD: reg_rdata = 32'(period_q);
      A_CTRL:   reg_rdata = ctrl_q;
      A_UWM:    reg_rdata = 32'(uwm_q);
      A_LWM:    reg_rdata = 32'(lwm_q);
      A_INIT:   reg_rdata = 32'(init_q);
      A_AVG_HI: reg_rdata = 32'(ahi_q);
      A_AVG_LO: reg_rdata = 32'(alo_q);
      A_WEIGHT: reg_rdata = 32'(weight_q);
      A_AVG:    reg_rdata = chan_en ? 32'(avg_q) : 32'(init_q);
      A_STATUS: reg_rdata = {status_q, 28'd0};
      default:  reg_rdata = '0;
    endcase
  end

  // R10
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_wr && !sample_en) |=> $stable(status_q))
    else $error("status changed with no event and no clear");

  // R11
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status_q != 4'b0000))
    else $error("interrupt with empty status");

  // R12
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_en && !status_wr) |=> (status_q == $past(status_q)))
    else $error("flag raised while stopped");

endmodule

// File: tb/sim_bus_activity_monitor.sv
`timescale 1ns/1ps
module sim_bus_activity_monitor;
  import mon_pkg::*;

  localparam int CW = 16;
  localparam int WW = 16;
  localparam int PW = 8;
  localparam longint LIMV = (64'd1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_strobe = 1'b0;
  logic bus_event = 1'b0;
  logic reg_wr = 1'b0;
  logic [5:0] reg_addr = 6'h0;
  logic [31:0] reg_wdata = 32'h0;
  wire  [31:0] reg_rdata;
  wire         irq;

  always #2.5 clk = ~clk;

  bus_activity_monitor #(.DATA_W(CW), .WEIGHT_W(WW), .PERIOD_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .ms_strobe(ms_strobe), .bus_event(bus_event),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  int density = 0;
  int strobe_div = 0;
  int rot = 0;

  // ---------------- reference model ----------------
  logic [31:0] m_period, m_ctrl, m_uwm, m_lwm, m_init, m_ahi, m_alo, m_weight;
  longint      m_acc, m_avg;
  int          m_tcnt, m_cu, m_cl;
  logic [3:0]  m_status;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_period = 0; m_ctrl = 0; m_uwm = 0; m_lwm = 0; m_init = 0;
      m_ahi = 0; m_alo = 0; m_weight = 0; m_acc = 0; m_avg = 0;
      m_tcnt = 0; m_cu = 0; m_cl = 0; m_status = 0;
    end else begin
      bit tick;
      logic [3:0] evt;
      longint s;
      int k;
      evt = 0;
      tick = ms_strobe && (m_tcnt >= int'(m_period));
      if (tick) m_tcnt = 0;
      else if (ms_strobe) m_tcnt = m_tcnt + 1;
      if (!m_ctrl[31]) begin
        m_acc = 0; m_cu = 0; m_cl = 0; m_avg = longint'(m_init);
      end else begin
        if (!m_ctrl[30]) m_cu = 0;
        if (!m_ctrl[29]) m_cl = 0;
        s = m_acc + (bus_event ? longint'(m_weight) : 0);
        if (s > LIMV) s = LIMV;
        if (tick && m_ctrl[18]) begin
          if (m_ctrl[30]) begin
            if (s > longint'(m_uwm)) begin
              if (m_cu >= int'(m_ctrl[28:26])) begin evt[3] = 1; m_cu = 0; end
              else m_cu = m_cu + 1;
            end else m_cu = 0;
          end
          if (m_ctrl[29]) begin
            if (s < longint'(m_lwm)) begin
              if (m_cl >= int'(m_ctrl[25:23])) begin evt[2] = 1; m_cl = 0; end
              else m_cl = m_cl + 1;
            end else m_cl = 0;
          end
          k = int'(m_ctrl[13:10]) + 1;
          if (s >= m_avg) m_avg = m_avg + ((s - m_avg) >> k);
          else            m_avg = m_avg - ((m_avg - s) >> k);
          if (m_ctrl[21] && m_avg > longint'(m_ahi)) evt[1] = 1;
          if (m_ctrl[20] && m_avg < longint'(m_alo)) evt[0] = 1;
          m_acc = 0;
        end else m_acc = s;
      end
      if (reg_wr) begin
        case (reg_addr)
          A_PERIOD: m_period = reg_wdata & 32'h0000_00FF;
          A_CTRL:   m_ctrl   = reg_wdata;
          A_UWM:    m_uwm    = reg_wdata & 32'h0000_FFFF;
          A_LWM:    m_lwm    = reg_wdata & 32'h0000_FFFF;
          A_INIT:   m_init   = reg_wdata & 32'h0000_FFFF;
          A_AVG_HI: m_ahi    = reg_wdata & 32'h0000_FFFF;
          A_AVG_LO: m_alo    = reg_wdata & 32'h0000_FFFF;
          A_WEIGHT: m_weight = reg_wdata & 32'h0000_FFFF;
          A_STATUS: m_status = m_status & ~reg_wdata[31:28];
          default: ;
        endcase
      end
      m_status = m_status | evt;
    end
  end

  function automatic logic [31:0] m_read(input logic [5:0] a);
    case (a)
      A_PERIOD: return m_period;
      A_CTRL:   return m_ctrl;
      A_UWM:    return m_uwm;
      A_LWM:    return m_lwm;
      A_INIT:   return m_init;
      A_AVG_HI: return m_ahi;
      A_AVG_LO: return m_alo;
      A_WEIGHT: return m_weight;
      A_AVG:    return m_ctrl[31] ? 32'(m_avg) : m_init;
      A_STATUS: return {m_status, 28'd0};
      default:  return 32'd0;
    endcase
  endfunction

  function automatic logic m_irq();
    return |(m_status & {m_ctrl[30], m_ctrl[29], m_ctrl[21], m_ctrl[20]});
  endfunction

  function automatic string tag_of(input logic [5:0] a);
    case (a)
      A_AVG:    return "R4/R5 average";
      A_STATUS: return "R6/R7/R9/R10 status";
      default:  return "R13 register";
    endcase
  endfunction

  // ---------------- per-clock comparison ----------------
  always @(negedge clk) begin
    if (rst_n && !done) begin
      compared++;
      if (reg_rdata !== m_read(reg_addr)) begin
        mismatched++;
        $display("FAIL %s addr %0h: actual %0h expected %0h",
                 tag_of(reg_addr), reg_addr, reg_rdata, m_read(reg_addr));
      end
      compared++;
      if (irq !== m_irq()) begin
        mismatched++;
        $display("FAIL R11 irq: actual %0b expected %0b", irq, m_irq());
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  localparam logic [5:0] ROT [10] = '{A_PERIOD, A_CTRL, A_AVG, A_STATUS, A_UWM,
                                       A_AVG, A_LWM, A_STATUS, A_INIT, A_WEIGHT};

  task automatic drive_common();
    @(negedge clk); #1;
    strobe_div = (strobe_div + 1) % 4;
    ms_strobe = (strobe_div == 0);
    bus_event = ($urandom % 100) < density;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      drive_common();
      reg_wr = 1'b0;
      rot = (rot + 1) % 10;
      reg_addr = ROT[rot];
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    drive_common();
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
  endtask

  // read through the port and compare against a literal expectation
  task automatic expect_rd(input string tag, input logic [5:0] a,
                           input logic [31:0] exp);
    drive_common();
    reg_wr = 1'b0; reg_addr = a;
    @(negedge clk);
    compared++;
    if (reg_rdata !== exp) begin
      mismatched++;
      $display("FAIL %s addr %0h: actual %0h expected %0h", tag, a, reg_rdata, exp);
    end
  endtask

  // read through the port and compare against the model under a named requirement
  task automatic probe(input string tag, input logic [5:0] a);
    drive_common();
    reg_wr = 1'b0; reg_addr = a;
    @(negedge clk);
    compared++;
    if (reg_rdata !== m_read(a) || irq !== m_irq()) begin
      mismatched++;
      $display("FAIL %s addr %0h: actual %0h/%0b expected %0h/%0b", tag, a,
               reg_rdata, irq, m_read(a), m_irq());
    end
  endtask

  localparam logic [31:0] CTRL_ALL = 32'hE534_0400; // K=1, up N=1, low N=2

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 10; i++) expect_rd("R1 reset value", ROT[i], 32'h0);
    expect_rd("R1 unmapped/R13", 6'h3C, 32'h0);
    compared++;
    if (irq !== 1'b0) begin
      mismatched++; $display("FAIL R1 irq: actual %0b expected 0", irq);
    end

    // R13 register programming, R5 initial average while disabled
    wr(A_PERIOD, 32'h0000_0101);
    wr(A_WEIGHT, 32'h0001_0028);
    wr(A_UWM, 200); wr(A_LWM, 60); wr(A_INIT, 150);
    wr(A_AVG_HI, 220); wr(A_AVG_LO, 80);
    expect_rd("R13 period truncated", A_PERIOD, 32'h1);
    expect_rd("R13 weight truncated", A_WEIGHT, 32'h28);
    expect_rd("R5 average shows init while stopped", A_AVG, 150);

    // R3 R4 R6 R9 heavy traffic
    wr(A_CTRL, CTRL_ALL);
    density = 90; idle(300);
    probe("R6 consecutive-above flag", A_STATUS);
    probe("R4 average after heavy traffic", A_AVG);
    probe("R9 average above band", A_STATUS);

    // R10 clear all
    density = 0;
    wr(A_STATUS, 32'hFFFF_FFFF);
    probe("R10 status cleared", A_STATUS);

    // R7 R8 R9 light traffic
    density = 8; idle(400);
    probe("R7 consecutive-below flag", A_STATUS);
    probe("R9 average below band", A_AVG);
    density = 50; idle(300);
    probe("R8 mixed traffic streaks", A_STATUS);

    // R2 longer period, different K
    wr(A_PERIOD, 5);
    wr(A_CTRL, CTRL_ALL | (32'd3 << 10));
    density = 70; idle(400);
    probe("R2 period of six strobes", A_AVG);

    // R11 masking: flags kept, sources disabled
    wr(A_CTRL, 32'h8004_0000);
    idle(20);
    probe("R11 irq masked by enables", A_STATUS);
    wr(A_CTRL, CTRL_ALL);
    idle(20);
    probe("R11 irq restored", A_STATUS);

    // R10 set-versus-clear collisions
    for (int i = 0; i < 300; i++) begin
      density = (i < 150) ? 95 : 3;
      wr(A_STATUS, 32'hFFFF_FFFF);
    end
    probe("R10 set wins over clear", A_STATUS);

    // R3 periodic sampling off: accumulation continues and saturates
    wr(A_WEIGHT, 32'h0000_FFFF);
    wr(A_CTRL, CTRL_ALL & ~32'h0004_0000);
    density = 100; idle(100);
    wr(A_CTRL, CTRL_ALL);
    idle(60);
    probe("R3 saturated sample", A_AVG);

    // R12 stop and restart
    wr(A_CTRL, 32'h0);
    idle(100);
    probe("R12 no flags while stopped", A_STATUS);
    expect_rd("R5 average reloads init", A_AVG, 150);
    wr(A_WEIGHT, 40); wr(A_PERIOD, 1);
    wr(A_CTRL, CTRL_ALL & ~32'h0000_3C00);
    density = 60; idle(300);
    probe("R12 restart from clean state", A_AVG);
    probe("R6 after restart", A_STATUS);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule